// File: doc/BRIEF.md
# Shared-Window IDE Configuration Register File

This block sits on the eight-byte primary IDE task-file window and hides a small register file behind it. After reset the window belongs to the drive channel. The block only watches the accesses and drives all-ones on read data. A covert unlock changes this: a fixed number of 16-bit reads at the error/feature offset (offset 1) switches the window into configuration mode. In that mode, byte offsets reach internal registers. Each register has its own write mask, and two of the offsets are banked.

A control write at offset 2 returns the window to the drive channel. The same write can also set a lock flag. Once the lock is set, no unlock sequence works again until reset. A firmware handler in system management mode can read back the stored control bits through offset 2. Outside that mode, those bits read as zero. The primary-channel enable output gates the drive channel. It is high only in normal mode, and only while the enable bit of the channel register is set.

Accesses are single-cycle strobes on a plain register bus. A word or dword access is treated as a series of byte accesses, lowest byte first.

Top module: `ide_cfg_unlock`

## Requirements
- R1: After reset, `cfg_mode` is 0 and `pri_en` is 1. The control register holds 0x80, the channel register (offset 3) holds 0x01 and the timing register (offset 5) holds 0x20. Offset 4 and all four bank bytes hold 0x00, and the lock flag is clear.
- R2: A read with `acc_size`=1 (word) at offset 1 in normal mode advances a counter modulo UNLOCK_READS (default 2). When the counter wraps to 0 and the lock flag is clear, `cfg_mode` becomes 1 on the following cycle. Byte reads, reads at other offsets and reads made in configuration mode do not advance the counter.
- R3: In configuration mode, offsets 0 and 1 reach bank byte 0 or 1. Bit 0 of the offset-6 register selects the bank: 0 selects the first bank and 1 selects the second bank.
- R4: A write at offset 2 stores (data AND 0xC1) OR 0x02 into the control register. If data bit 7 or bit 6 is 1, `cfg_mode` returns to 0 after the access.
- R5: A write at offset 2 with data bit 6 set sets the lock flag. While the lock flag is set, unlock reads never enter configuration mode. Only reset clears the lock flag.
- R6: A write at offset 3 stores the data with bit 5 cleared. `pri_en` equals (NOT `cfg_mode`) AND bit 0 of this register.
- R7: A write at offset 5 replaces bits 7 and 2:0. Bits 6:3 keep their value.
- R8: A write at offset 6 stores all 8 bits. Writes at offsets 4 and 7 change nothing.
- R9: A read at offset 2 returns `smm_act` in bit 7. When `smm_act` is 1, bits 6:0 return the control register bits 6:0. When `smm_act` is 0, bits 6:0 read as 0.
- R10: Reads at offsets 3, 4, 5 and 6 return the stored byte. A read at offset 7 returns 0xFF.
- R11: `acc_size` 0/1/2 means 1/2/4 bytes, and 3 means no access. Byte k of an access goes to offset (`acc_addr`+k) mod 8 and appears on `rdata[8k+7:8k]`. The bytes of a write are applied in order, so a later byte sees the effect of an earlier one. Lanes beyond the access size read 0xFF.
- R12: In normal mode every read returns all ones and writes leave the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 3 | Byte offset within the task-file window |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword, 3 none |
| acc_rd | input | 1 | Read strobe, one cycle |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_wdata | input | 8*MAX_BYTES | Write data, lane k for byte k |
| smm_act | input | 1 | Processor is in system management mode |
| rdata | output | 8*MAX_BYTES | Read data for the current strobe |
| cfg_mode | output | 1 | Window is in configuration mode |
| pri_en | output | 1 | Primary drive channel enable |

## Verification
The assertions check the following on every cycle:
- the lock flag is sticky;
- configuration mode is never entered while locked, and is entered only right after an unlock read;
- `pri_en` is low throughout configuration mode;
- bits 6:3 of the timing register never move, the control register keeps bits 5:2 at zero, and the channel register keeps bit 5 at zero;
- normal mode leaves the register file untouched.

Only the bench scenarios can show the following:
- the exact byte values stored through each mask;
- bank steering;
- lane ordering and offset wrap in dword accesses;
- the SMM masking of reads;
- the unlock count.

The bench shows these by sweeping every data value through the masked registers and comparing against arithmetic expectations.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

   localparam int OFS_W = 3;

   localparam logic [OFS_W-1:0] OFS_BANK_LO = 3'd0;
   localparam logic [OFS_W-1:0] OFS_BANK_HI = 3'd1;
   localparam logic [OFS_W-1:0] OFS_CTL     = 3'd2;
   localparam logic [OFS_W-1:0] OFS_CHAN    = 3'd3;
   localparam logic [OFS_W-1:0] OFS_SPARE   = 3'd4;
   localparam logic [OFS_W-1:0] OFS_TIMING  = 3'd5;
   localparam logic [OFS_W-1:0] OFS_SELECT  = 3'd6;

   localparam logic [7:0] CTL_KEEP  = 8'hC1;
   localparam logic [7:0] CTL_FORCE = 8'h02;
   localparam logic [7:0] CHAN_KEEP = 8'hDF;
   localparam logic [7:0] TIM_WMASK = 8'h87;

   typedef struct packed {
      logic [7:0]      ctl;
      logic [7:0]      sel;
      logic [7:0]      timing;
      logic [7:0]      spare;
      logic [7:0]      chan;
      logic [1:0][7:0] bank1;
      logic [1:0][7:0] bank0;
   } cfg_regs_t;

endpackage

// File: rtl/ide_cfg_wr_lane.sv
module ide_cfg_wr_lane
   import ide_cfg_pkg::*;
(
   input  cfg_regs_t        st_i,
   input  logic             en_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic [7:0]       d_i,
   output cfg_regs_t        st_o,
   output logic             exit_o,
   output logic             lock_o
);

   always_comb begin
      st_o   = st_i;
      exit_o = 1'b0;
      lock_o = 1'b0;
      if (en_i) begin
         unique case (ofs_i)
            OFS_BANK_LO, OFS_BANK_HI: begin
               if (st_i.sel[0]) st_o.bank1[ofs_i[0]] = d_i;
               else             st_o.bank0[ofs_i[0]] = d_i;
            end
            OFS_CTL: begin
               st_o.ctl = (d_i & CTL_KEEP) | CTL_FORCE;
               exit_o   = d_i[7] | d_i[6];
               lock_o   = d_i[6];
            end
            OFS_CHAN:   st_o.chan   = d_i & CHAN_KEEP;
            OFS_TIMING: st_o.timing = (st_i.timing & ~TIM_WMASK) | (d_i & TIM_WMASK);
            OFS_SELECT: st_o.sel    = d_i;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ide_cfg_rd_lane.sv
module ide_cfg_rd_lane
   import ide_cfg_pkg::*;
(
   input  cfg_regs_t        st_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic             smm_i,
   output logic [7:0]       q_o
);

   always_comb begin
      unique case (ofs_i)
         OFS_BANK_LO, OFS_BANK_HI:
            q_o = st_i.sel[0] ? st_i.bank1[ofs_i[0]] : st_i.bank0[ofs_i[0]];
         OFS_CTL:    q_o = smm_i ? {1'b1, st_i.ctl[6:0]} : 8'h00;
         OFS_CHAN:   q_o = st_i.chan;
         OFS_SPARE:  q_o = st_i.spare;
         OFS_TIMING: q_o = st_i.timing;
         OFS_SELECT: q_o = st_i.sel;
         default:    q_o = 8'hFF;
      endcase
   end

endmodule

// File: rtl/ide_cfg_mode.sv
module ide_cfg_mode #(
   parameter int UNLOCK_READS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic probe_i,
   input  logic exit_i,
   input  logic lock_i,
   output logic cfg_mode_o,
   output logic locked_o
);

   localparam int CNT_W = (UNLOCK_READS > 2) ? $clog2(UNLOCK_READS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNLOCK_READS - 1);

   generate
      if (UNLOCK_READS < 2) begin : g_bad_reads
         $error("UNLOCK_READS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cfg_mode_o <= 1'b0;
         locked_o   <= 1'b0;
      end else begin
         if (probe_i && !cfg_mode_o) begin
            if (cnt_q == CNT_LAST) begin
               cnt_q <= '0;
               if (!locked_o) cfg_mode_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (exit_i) cfg_mode_o <= 1'b0;
         if (lock_i) locked_o   <= 1'b1;
      end
   end

   p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> locked_o);

   p_no_reentry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && !cfg_mode_o) |=> !cfg_mode_o);

   p_entry_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode_o && !probe_i) |=> !cfg_mode_o);

endmodule

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
   import ide_cfg_pkg::*;
#(
   parameter int         MAX_BYTES    = 4,
   parameter int         UNLOCK_READS = 2,
   parameter logic [7:0] CTL_INIT     = 8'h80,
   parameter logic [7:0] CHAN_INIT    = 8'h01,
   parameter logic [7:0] TIM_INIT     = 8'h20,
   localparam int        DATA_W       = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  acc_addr,
   input  logic [1:0]        acc_size,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              smm_act,
   output logic [DATA_W-1:0] rdata,
   output logic              cfg_mode,
   output logic              pri_en
);

   localparam int NB_W = 3;

   generate
      if (MAX_BYTES != 2 && MAX_BYTES != 4) begin : g_bad_lanes
         $error("MAX_BYTES must be 2 or 4");
      end
      if (CTL_INIT[5:2] != 4'h0 || CHAN_INIT[5] != 1'b0) begin : g_bad_init
         $error("reset values violate the register write masks");
      end
   endgenerate

   cfg_regs_t regs_q;
   cfg_regs_t st_chain [MAX_BYTES+1];
   logic [MAX_BYTES-1:0] lane_exit, lane_lock;
   logic [NB_W-1:0] nbytes;
   logic wr_go, probe, locked;

   always_comb begin
      unique case (acc_size)
         2'd0:    nbytes = NB_W'(1);
         2'd1:    nbytes = NB_W'(2);
         2'd2:    nbytes = (MAX_BYTES >= 4) ? NB_W'(4) : NB_W'(0);
         default: nbytes = NB_W'(0);
      endcase
   end

   assign wr_go = acc_wr && cfg_mode;
   assign probe = acc_rd && !acc_wr && (acc_size == 2'd1) && (acc_addr == OFS_BANK_HI);
   assign st_chain[0] = regs_q;

   for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
      logic [OFS_W-1:0] ofs;
      logic             in_acc;
      logic [7:0]       q;

      assign ofs    = acc_addr + OFS_W'(k);
      assign in_acc = (NB_W'(k) < nbytes);

      ide_cfg_wr_lane u_wr (
         .st_i   (st_chain[k]),
         .en_i   (wr_go && in_acc),
         .ofs_i  (ofs),
         .d_i    (acc_wdata[8*k +: 8]),
         .st_o   (st_chain[k+1]),
         .exit_o (lane_exit[k]),
         .lock_o (lane_lock[k])
      );

      ide_cfg_rd_lane u_rd (
         .st_i  (regs_q),
         .ofs_i (ofs),
         .smm_i (smm_act),
         .q_o   (q)
      );

      assign rdata[8*k +: 8] = (cfg_mode && in_acc) ? q : 8'hFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs_q        <= '0;
         regs_q.ctl    <= CTL_INIT;
         regs_q.chan   <= CHAN_INIT;
         regs_q.timing <= TIM_INIT;
      end else if (wr_go) begin
         regs_q <= st_chain[MAX_BYTES];
      end
   end

   ide_cfg_mode #(.UNLOCK_READS(UNLOCK_READS)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .probe_i    (probe),
      .exit_i     (wr_go && (|lane_exit)),
      .lock_i     (wr_go && (|lane_lock)),
      .cfg_mode_o (cfg_mode),
      .locked_o   (locked)
   );

   assign pri_en = !cfg_mode && regs_q.chan[0];

   p_pri_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |-> !pri_en);

   p_chan_bit5_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !regs_q.chan[5]);

   p_ctl_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      regs_q.ctl[5:2] == 4'h0);

   p_tim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(regs_q.timing[6:3]));

   p_normal_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> $stable(regs_q));

   p_lock_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !cfg_mode) |=> !cfg_mode);

endmodule

// File: tb/ide_cfg_unlock_tb.sv
module ide_cfg_unlock_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  acc_addr;
   logic [1:0]  acc_size;
   logic        acc_rd, acc_wr, smm_act;
   logic [31:0] acc_wdata, rdata;
   logic        cfg_mode, pri_en;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   ide_cfg_unlock u_dut (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
      .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .smm_act(smm_act), .rdata(rdata), .cfg_mode(cfg_mode), .pri_en(pri_en)
   );

   logic [7:0] m_b0 [2];
   logic [7:0] m_b1 [2];
   logic [7:0] m_ch, m_sp, m_tm, m_sel, m_ctl;
   bit m_cfg, m_lock;
   int m_cnt;

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string rq);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] mrd(input int o, input bit smm);
      case (o)
         0, 1: return m_sel[0] ? m_b1[o] : m_b0[o];
         2: return smm ? {1'b1, m_ctl[6:0]} : 8'h00;
         3: return m_ch;
         4: return m_sp;
         5: return m_tm;
         6: return m_sel;
         default: return 8'hFF;
      endcase
   endfunction

   task automatic mwr(input int o, input logic [7:0] d, inout bit ex, inout bit lk);
      case (o)
         0, 1: if (m_sel[0]) m_b1[o] = d; else m_b0[o] = d;
         2: begin m_ctl = (d & 8'hC1) | 8'h02; if (d[7] || d[6]) ex = 1; if (d[6]) lk = 1; end
         3: m_ch = d & 8'hDF;
         5: m_tm = {d[7], m_tm[6:3], d[2:0]};
         6: m_sel = d;
         default: ;
      endcase
   endtask

   task automatic do_reset();
      rst_n = 1'b0; acc_rd = 0; acc_wr = 0; acc_addr = 0; acc_size = 0;
      acc_wdata = 0; smm_act = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      m_b0[0] = 0; m_b0[1] = 0; m_b1[0] = 0; m_b1[1] = 0;
      m_ch = 8'h01; m_sp = 0; m_tm = 8'h20; m_sel = 0; m_ctl = 8'h80;
      m_cfg = 0; m_lock = 0; m_cnt = 0;
   endtask

   task automatic acc(input int a, input int sz, input bit wr, input logic [31:0] d,
                      input bit smm, input string rq);
      int nb;
      bit ex, lk;
      logic [31:0] exp;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
      @(negedge clk);
      acc_addr = 3'(a); acc_size = 2'(sz); acc_wr = wr; acc_rd = !wr;
      acc_wdata = d; smm_act = smm;
      #1;
      if (!wr) begin
         exp = '1;
         if (m_cfg) for (int k = 0; k < nb; k++) exp[8*k +: 8] = mrd((a + k) % 8, smm);
         check(rdata, exp, rq);
      end
      @(posedge clk); #1;
      acc_rd = 0; acc_wr = 0;
      if (wr && m_cfg) begin
         ex = 0; lk = 0;
         for (int k = 0; k < nb; k++) mwr((a + k) % 8, d[8*k +: 8], ex, lk);
         if (lk) m_lock = 1;
         if (ex) m_cfg = 0;
      end
      if (!wr && !m_cfg && sz == 1 && a == 1) begin
         m_cnt = (m_cnt + 1) % 2;
         if (m_cnt == 0 && !m_lock) m_cfg = 1;
      end
   endtask

   task automatic chk_mode(input string rq);
      @(negedge clk); #1;
      check({30'd0, cfg_mode, pri_en}, {30'd0, m_cfg, !m_cfg && m_ch[0]}, rq);
   endtask

   task automatic unlock();
      acc(1, 1, 0, 0, 0, "R2");
      acc(1, 1, 0, 0, 0, "R2");
   endtask

   task automatic read_all(input bit smm, input string rq);
      for (int o = 0; o < 8; o++) acc(o, 0, 0, 0, smm, rq);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state, R12 normal reads
      chk_mode("R1");
      acc(1, 0, 0, 0, 0, "R12");
      acc(0, 2, 0, 0, 1, "R12");
      // R12: normal write has no effect
      acc(3, 0, 1, 32'h00, 0, "R12");
      chk_mode("R12");
      // R2: partial sequence and non-counting reads
      acc(1, 1, 0, 0, 0, "R2");
      chk_mode("R2");
      acc(1, 0, 0, 0, 0, "R2");
      acc(0, 1, 0, 0, 0, "R2");
      acc(1, 2, 0, 0, 0, "R2");
      chk_mode("R2");
      acc(1, 1, 0, 0, 0, "R2");
      chk_mode("R2");
      // R1 reset values, R12 ignored write
      read_all(1, "R1");
      read_all(0, "R9");
      // R2: reads in cfg mode do not count
      acc(1, 1, 0, 0, 0, "R2");
      acc(1, 1, 0, 0, 0, "R2");
      chk_mode("R2");
      // R6 sweep
      for (int v = 0; v < 256; v++) begin
         acc(3, 0, 1, 32'(v), 0, "R6");
         acc(3, 0, 0, 0, 0, "R6");
      end
      acc(3, 0, 1, 32'h01, 0, "R6");
      // R7 sweep
      for (int v = 0; v < 256; v++) begin
         acc(5, 0, 1, 32'(v), 0, "R7");
         acc(5, 0, 0, 0, 0, "R7");
      end
      // R8 sweep, offsets 4 and 7
      for (int v = 0; v < 256; v++) begin
         acc(6, 0, 1, 32'(v), 0, "R8");
         acc(6, 0, 0, 0, 0, "R8");
      end
      acc(4, 0, 1, 32'h5C, 0, "R8");
      acc(7, 0, 1, 32'hA3, 0, "R8");
      read_all(1, "R10");
      // R3 banks
      acc(6, 0, 1, 32'h00, 0, "R3");
      acc(0, 1, 1, 32'h2211, 0, "R3");
      acc(6, 0, 1, 32'h01, 0, "R3");
      acc(0, 0, 1, 32'h33, 0, "R3");
      acc(1, 0, 1, 32'h44, 0, "R3");
      acc(0, 1, 0, 0, 0, "R3");
      acc(6, 0, 1, 32'h00, 0, "R3");
      acc(0, 1, 0, 0, 0, "R3");
      // R11 lane order, wrap, and later lanes seeing earlier
      acc(6, 2, 1, 32'h5AA5_0001, 0, "R11");
      acc(0, 1, 0, 0, 0, "R11");
      acc(6, 2, 1, 32'h6996_0000, 0, "R11");
      acc(0, 1, 0, 0, 0, "R11");
      acc(3, 2, 0, 0, 0, "R11");
      acc(5, 2, 0, 0, 1, "R11");
      acc(3, 3, 1, 32'hFFFF_FFFF, 0, "R11");
      acc(3, 3, 0, 0, 0, "R11");
      acc(3, 2, 0, 0, 0, "R11");
      // R4/R9 control sweep without exit
      for (int v = 0; v < 64; v++) begin
         acc(2, 0, 1, 32'(v), 0, "R4");
         acc(2, 0, 0, 0, 1, "R9");
         acc(2, 0, 0, 0, 0, "R9");
      end
      chk_mode("R4");
      // R4 exit via bit 7, R6 pri_en
      acc(2, 0, 1, 32'h80, 0, "R4");
      chk_mode("R4");
      acc(2, 0, 0, 0, 1, "R12");
      unlock();
      chk_mode("R2");
      acc(2, 0, 0, 0, 1, "R4");
      acc(3, 0, 1, 32'h00, 0, "R6");
      acc(2, 0, 1, 32'h80, 0, "R6");
      chk_mode("R6");
      unlock();
      acc(3, 0, 1, 32'h01, 0, "R6");
      // R5 lock
      acc(2, 0, 1, 32'h40, 0, "R5");
      chk_mode("R5");
      unlock();
      chk_mode("R5");
      unlock();
      chk_mode("R5");
      acc(2, 0, 0, 0, 1, "R5");
      // R5 reset clears lock
      do_reset();
      chk_mode("R1");
      unlock();
      chk_mode("R5");
      read_all(1, "R1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule